// File: doc/BRIEF.md
# Field Event Interrupt Unit

This unit sits beside a video timing generator and turns its per-field pulses into one host interrupt. Each bottom-field or top-field strobe sets its own bit in a 16-bit status register, whether or not that bit is enabled. A 16-bit enable mask selects which pending bits may raise the interrupt. The interrupt line is a level signal. It stays high while any status bit that is set is also enabled.

The host works through a simple register port: a write strobe with address and data, and a separate read address with combinational read data. Status bits are cleared only by writing ones to a dedicated clear address. The mask has no direct write address. It changes only through a bit-set address and a bit-clear address, so one enable can change without a read-modify-write. Software acknowledges an interrupt by reading the status and writing the same value back to the clear address. An event that arrives in the same cycle as its clear is kept, so no field pulse is lost.

Top module: `fim_unit`

## Requirements
- R1: After reset the status reads 0x0000, the mask reads 0x0000 and `irq` is low.
- R2: A pulse on `evt_bottom` sets status bit 0 and a pulse on `evt_top` sets status bit 1. Status reads at offset 0x78, and bits 15..2 always read zero.
- R3: A status bit is set by its event even when its mask bit is zero.
- R4: Writing to offset 0x7C clears each status bit whose data bit is one and leaves the status bits under zero data bits unchanged.
- R5: If an event and a clear of the same status bit occur in the same cycle, the bit ends up set.
- R6: Writing to offset 0x8C sets each mask bit whose data bit is one and leaves the other mask bits unchanged. The mask reads back at 0x8C.
- R7: Writing to offset 0x88 clears each mask bit whose data bit is one and leaves the other mask bits unchanged.
- R8: `irq` is high exactly when some bit is set in both status and mask, and it stays high until those bits are cleared.
- R9: Writes to 0x78 or to any address other than 0x7C, 0x88 and 0x8C change neither status nor mask.
- R10: Reads at any offset other than 0x78 and 0x8C return zero.
- R11: Writing 0xFFFF to 0x7C clears all status bits, and writing 0xFFFF to 0x88 clears all mask bits.
- R12: Reading the status and writing that value to 0x7C returns the status to zero and drops `irq` when no new event has arrived.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en | input | 1 | Write strobe, one cycle per write |
| wr_addr | input | 8 | Write byte offset |
| wr_data | input | 16 | Write data, one bit per status or mask bit |
| rd_addr | input | 8 | Read byte offset |
| rd_data | output | 16 | Read data for `rd_addr`, combinational |
| evt_bottom | input | 1 | Bottom-field event strobe |
| evt_top | input | 1 | Top-field event strobe |
| irq | output | 1 | Level interrupt request |

## Verification
The hardest case to reach is an acknowledge that races a new field pulse. This happens when a clear and an event for the same bit land in the same cycle, and the bit must survive while its neighbour is cleared. Directed steps place a top-field strobe in the same cycle as a clear write that covers bit 1. Random stimulus then mixes clear writes with both strobes at high rates, so both-bit collisions occur many times. A reference model, computed from the requirements, tracks status, mask and `irq` on every cycle.

// File: rtl/fim_pkg.sv
package fim_pkg;
  // Per-cycle write strobes, one bit per register bit
  typedef struct packed {
    logic [15:0] stat_clr;
    logic [15:0] mask_clr;
    logic [15:0] mask_set;
  } fim_wr_t;
endpackage

// File: rtl/fim_rst_sync.sv
module fim_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/fim_decode.sv
module fim_decode
  import fim_pkg::*;
#(
  parameter int unsigned ADDR_W       = 8,
  parameter int unsigned DATA_W       = 16,
  parameter logic [ADDR_W-1:0] OFS_STAT     = 8'h78,
  parameter logic [ADDR_W-1:0] OFS_STAT_CLR = 8'h7C,
  parameter logic [ADDR_W-1:0] OFS_MASK_CLR = 8'h88,
  parameter logic [ADDR_W-1:0] OFS_MASK_SET = 8'h8C
) (
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic [DATA_W-1:0] stat,
  input  logic [DATA_W-1:0] mask,
  output logic [DATA_W-1:0] stat_clr,
  output logic [DATA_W-1:0] mask_clr,
  output logic [DATA_W-1:0] mask_set,
  output logic [DATA_W-1:0] rd_data
);
  always_comb begin
    stat_clr = '0;
    mask_clr = '0;
    mask_set = '0;
    if (wr_en) begin
      if (wr_addr == OFS_STAT_CLR) stat_clr = wr_data;
      if (wr_addr == OFS_MASK_CLR) mask_clr = wr_data;
      if (wr_addr == OFS_MASK_SET) mask_set = wr_data;
    end
  end

  always_comb begin
    if (rd_addr == OFS_STAT)          rd_data = stat;
    else if (rd_addr == OFS_MASK_SET) rd_data = mask;
    else                              rd_data = '0;
  end
endmodule

// File: rtl/fim_status.sv
module fim_status #(
  parameter int unsigned DATA_W  = 16,
  parameter int unsigned NUM_EVT = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_EVT-1:0] evt,
  input  logic [DATA_W-1:0]  clr,
  output logic [DATA_W-1:0]  stat
);
  localparam int unsigned SPARE_W = DATA_W - NUM_EVT;

  logic [NUM_EVT-1:0] bit_q;
  logic [NUM_EVT-1:0] bit_en;
  logic [NUM_EVT-1:0] bit_d;

  for (genvar b = 0; b < NUM_EVT; b++) begin : g_bit
    // An event in the same cycle as a clear wins
    always_comb begin
      bit_en[b] = evt[b] | clr[b];
      bit_d[b]  = evt[b];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         bit_q[b] <= 1'b0;
      else if (bit_en[b]) bit_q[b] <= bit_d[b];
    end
  end

  assign stat = {{SPARE_W{1'b0}}, bit_q};
endmodule

// File: rtl/fim_mask.sv
module fim_mask #(
  parameter int unsigned DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] set,
  input  logic [DATA_W-1:0] clr,
  output logic [DATA_W-1:0] mask
);
  logic [DATA_W-1:0] mask_q;
  logic [DATA_W-1:0] mask_en;
  logic [DATA_W-1:0] mask_d;

  for (genvar b = 0; b < DATA_W; b++) begin : g_bit
    always_comb begin
      mask_en[b] = set[b] | clr[b];
      mask_d[b]  = set[b] & ~clr[b];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          mask_q[b] <= 1'b0;
      else if (mask_en[b]) mask_q[b] <= mask_d[b];
    end
  end

  assign mask = mask_q;
endmodule

// File: rtl/fim_irq.sv
module fim_irq #(
  parameter int unsigned DATA_W = 16
) (
  input  logic [DATA_W-1:0] stat,
  input  logic [DATA_W-1:0] mask,
  output logic              irq
);
  always_comb begin
    irq = |(stat & mask);
  end
endmodule

// File: rtl/fim_unit.sv
module fim_unit
  import fim_pkg::*;
#(
  parameter int unsigned ADDR_W  = 8,
  parameter int unsigned DATA_W  = 16,
  parameter int unsigned NUM_EVT = 2,
  parameter int unsigned RST_STAGES = 2,
  parameter logic [ADDR_W-1:0] OFS_STAT     = 8'h78,
  parameter logic [ADDR_W-1:0] OFS_STAT_CLR = 8'h7C,
  parameter logic [ADDR_W-1:0] OFS_MASK_CLR = 8'h88,
  parameter logic [ADDR_W-1:0] OFS_MASK_SET = 8'h8C
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  input  logic              evt_bottom,
  input  logic              evt_top,
  output logic              irq
);
  logic               rst_sync_n;
  logic [NUM_EVT-1:0] evt_vec;
  logic [DATA_W-1:0]  stat_q;
  logic [DATA_W-1:0]  mask_q;
  logic [DATA_W-1:0]  stat_clr;
  logic [DATA_W-1:0]  mask_clr;
  logic [DATA_W-1:0]  mask_set;

  // bit 0: bottom field, bit 1: top field
  assign evt_vec = {evt_top, evt_bottom};

  fim_rst_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  fim_decode #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W),
    .OFS_STAT(OFS_STAT), .OFS_STAT_CLR(OFS_STAT_CLR),
    .OFS_MASK_CLR(OFS_MASK_CLR), .OFS_MASK_SET(OFS_MASK_SET)
  ) u_dec (
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .rd_addr  (rd_addr),
    .stat     (stat_q),
    .mask     (mask_q),
    .stat_clr (stat_clr),
    .mask_clr (mask_clr),
    .mask_set (mask_set),
    .rd_data  (rd_data)
  );

  fim_status #(.DATA_W(DATA_W), .NUM_EVT(NUM_EVT)) u_stat (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .evt   (evt_vec),
    .clr   (stat_clr),
    .stat  (stat_q)
  );

  fim_mask #(.DATA_W(DATA_W)) u_mask (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .set   (mask_set),
    .clr   (mask_clr),
    .mask  (mask_q)
  );

  fim_irq #(.DATA_W(DATA_W)) u_irq (
    .stat (stat_q),
    .mask (mask_q),
    .irq  (irq)
  );
endmodule

// File: rtl/fim_unit_chk.sv
module fim_unit_chk #(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned DATA_W = 16,
  parameter logic [ADDR_W-1:0] OFS_STAT_CLR = 8'h7C,
  parameter logic [ADDR_W-1:0] OFS_MASK_CLR = 8'h88,
  parameter logic [ADDR_W-1:0] OFS_MASK_SET = 8'h8C
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [DATA_W-1:0] wr_data,
  input logic              evt_bottom,
  input logic              evt_top,
  input logic [DATA_W-1:0] stat,
  input logic [DATA_W-1:0] mask,
  input logic              irq
);
  logic wr_sclr, wr_mclr, wr_mset;
  assign wr_sclr = wr_en && (wr_addr == OFS_STAT_CLR);
  assign wr_mclr = wr_en && (wr_addr == OFS_MASK_CLR);
  assign wr_mset = wr_en && (wr_addr == OFS_MASK_SET);

  p_bot_sets_r2: assert property (@(posedge clk) disable iff (!rst_n)
    evt_bottom |=> stat[0]);

  p_top_wins_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_top && wr_sclr && wr_data[1]) |=> stat[1]);

  p_clr_bit0_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_sclr && wr_data[0] && !evt_bottom) |=> !stat[0]);

  p_mset_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_mset && wr_data[0]) |=> mask[0]);

  p_mclr_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_mclr && wr_data[1]) |=> !mask[1]);

  p_irq_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !wr_sclr && !wr_mclr) |=> irq);

  p_irq_rise_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_top && mask[1] && !wr_mclr) |=> irq);

  p_stat_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!evt_bottom && !evt_top && !wr_sclr) |=> $stable(stat));

  p_mask_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_mset && !wr_mclr) |=> $stable(mask));
endmodule

bind fim_unit fim_unit_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W),
  .OFS_STAT_CLR(OFS_STAT_CLR), .OFS_MASK_CLR(OFS_MASK_CLR),
  .OFS_MASK_SET(OFS_MASK_SET)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_sync_n),
  .wr_en      (wr_en),
  .wr_addr    (wr_addr),
  .wr_data    (wr_data),
  .evt_bottom (evt_bottom),
  .evt_top    (evt_top),
  .stat       (stat_q),
  .mask       (mask_q),
  .irq        (irq)
);

// File: tb/test_fim_unit.sv
module test_fim_unit;
  localparam int CLK_PERIOD = 10;

  logic        clk;
  logic        rst_n;
  logic        wr_en;
  logic [7:0]  wr_addr;
  logic [15:0] wr_data;
  logic [7:0]  rd_addr;
  logic [15:0] rd_data;
  logic        evt_bottom;
  logic        evt_top;
  logic        irq;

  int checks;
  int failures;
  bit done;
  logic [15:0] m_stat;
  logic [15:0] m_mask;

  fim_unit i_fim_unit (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
    .evt_bottom(evt_bottom), .evt_top(evt_top), .irq(irq)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [15:0] f_stat(logic [15:0] st, logic w, logic [7:0] a,
                                         logic [15:0] d, logic eb, logic et);
    logic [15:0] c;
    c = (w && a == 8'h7C) ? d : 16'h0;
    return (st & ~c) | {14'h0, et, eb};
  endfunction

  function automatic logic [15:0] f_mask(logic [15:0] mk, logic w, logic [7:0] a,
                                         logic [15:0] d);
    logic [15:0] r;
    r = mk;
    if (w && a == 8'h8C) r = r | d;
    if (w && a == 8'h88) r = r & ~d;
    return r;
  endfunction

  function automatic logic [15:0] f_read(logic [7:0] a);
    if (a == 8'h78) return m_stat;
    if (a == 8'h8C) return m_mask;
    return 16'h0;
  endfunction

  task automatic check(logic [15:0] act, logic [15:0] exp, string tag);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Drive one cycle at the falling edge, then compare after the next rising edge
  task automatic step(logic w, logic [7:0] a, logic [15:0] d, logic eb, logic et,
                      logic [7:0] ra, string tag);
    wr_en = w; wr_addr = a; wr_data = d; evt_bottom = eb; evt_top = et; rd_addr = ra;
    @(posedge clk);
    m_stat = f_stat(m_stat, w, a, d, eb, et);
    m_mask = f_mask(m_mask, w, a, d);
    @(negedge clk);
    wr_en = 1'b0; evt_bottom = 1'b0; evt_top = 1'b0;
    check(rd_data, f_read(ra), tag);
    check({15'h0, irq}, {15'h0, |(m_stat & m_mask)}, tag);
  endtask

  task automatic peek(logic [7:0] ra, string tag);
    rd_addr = ra;
    #1;
    check(rd_data, f_read(ra), tag);
  endtask

  initial begin
    logic [15:0] ack;
    checks = 0; failures = 0; done = 1'b0;
    m_stat = '0; m_mask = '0;
    rst_n = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0;
    rd_addr = 8'h78; evt_bottom = 1'b0; evt_top = 1'b0;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    peek(8'h78, "R1 status after reset");
    peek(8'h8C, "R1 mask after reset");
    check({15'h0, irq}, 16'h0, "R1 irq after reset");

    // R2 R3 events latch while masked off
    step(0, 8'h00, 16'h0, 1, 0, 8'h78, "R2 R3 bottom event sets bit 0");
    step(0, 8'h00, 16'h0, 0, 1, 8'h78, "R2 R3 top event sets bit 1");
    // R4 clear bit 0 only
    step(1, 8'h7C, 16'h0001, 0, 0, 8'h78, "R4 clear bit 0 only");
    // R6 set mask bit 1, read back, irq rises (R8)
    step(1, 8'h8C, 16'h0002, 0, 0, 8'h8C, "R6 R8 mask set readback");
    // R9 write to status offset ignored; zero data at set address ignored
    step(1, 8'h78, 16'hFFFF, 0, 0, 8'h78, "R9 write to status offset");
    step(1, 8'h40, 16'hFFFF, 0, 0, 8'h8C, "R9 write to unmapped offset");
    step(1, 8'h8C, 16'h0000, 0, 0, 8'h8C, "R6 zero data keeps mask");
    // R5 event and clear collide on bit 1
    step(1, 8'h7C, 16'h0002, 0, 1, 8'h78, "R5 event beats clear");
    // R8 level held across idle cycles
    step(0, 8'h00, 16'h0, 0, 0, 8'h78, "R8 irq held");
    // R12 acknowledge by writing back the read value
    rd_addr = 8'h78; #1; ack = rd_data;
    step(1, 8'h7C, ack, 0, 0, 8'h78, "R12 acknowledge");
    // R7 mask clear leaves other bits
    step(1, 8'h8C, 16'hFFFF, 0, 0, 8'h8C, "R6 set all mask");
    step(1, 8'h88, 16'h00F0, 0, 0, 8'h8C, "R7 clear some mask bits");
    // R10 reads of other offsets
    peek(8'h7C, "R10 read of status clear offset");
    peek(8'h88, "R10 read of mask clear offset");
    peek(8'h00, "R10 read of unmapped offset");
    // R11 clear everything
    step(0, 8'h00, 16'h0, 1, 1, 8'h78, "R11 both events");
    step(1, 8'h7C, 16'hFFFF, 0, 0, 8'h78, "R11 clear all status");
    step(1, 8'h88, 16'hFFFF, 0, 0, 8'h8C, "R11 clear all mask");

    // Random mix, heavy on clears and events
    for (int i = 0; i < 1500; i++) begin
      logic [7:0] a;
      logic [7:0] ra;
      logic [15:0] d;
      case ($urandom_range(0, 5))
        0: a = 8'h78; 1, 2: a = 8'h7C; 3: a = 8'h88; 4: a = 8'h8C; default: a = 8'h44;
      endcase
      ra = ($urandom_range(0, 2) == 0) ? 8'h8C : 8'h78;
      d = ($urandom_range(0, 3) == 0) ? 16'(32'($urandom)) : {14'h0, 2'($urandom_range(0, 3))};
      step(1'($urandom_range(0, 1)), a, d, 1'($urandom_range(0, 1)),
           1'($urandom_range(0, 1)), ra, "R2 R4 R5 R6 R7 R8 random");
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule